// File: doc/BRIEF.md
# Serial Link Mode and Direction Controller

This block is the control core of a bidirectional 12-bit serial link endpoint. Two range-select pins choose either power-down or one of three reference-frequency bands. A direction input makes the endpoint a serializer (high) or a deserializer (low), and a multiplier-select input picks standard or overclocked bit-clock generation. From these inputs the block produces a registered mode code, enables for the serializer and deserializer datapaths and for the output drivers, a power-down request, and routing selects for the two clock outputs.

The direction output is a combinational inverse of the direction input. It is used to drive the direction input of a partner endpoint. A direction change inserts a one-clock quiet gap in which neither datapath is enabled, so the shared parallel port is never driven from both sides. In serializer mode a sticky clock-source latch starts on the received bit clock. It moves to the local reference the first time reference activity is seen, and it stays there until the next power-down or reset.

Top module: `serdes_mode_ctl`

## Requirements
- R1: With range code {s2,s1}=00 sampled at a clock edge, the outputs after that edge are: pwrdn=1, mode_code=0, rate_band=0, overclock=0, ser_en=des_en=par_out_en=ser_out_en=0, cksource_ref=0, txclk_sel=0 and wclk_sel=0.
- R2: For a non-zero range code, rate_band and mode_code[1:0] equal {s2,s1} one clock after it is sampled. The codes are 1 for the 20–40 MHz band, 2 for the 5–14 MHz band and 3 for the 8–28 MHz band.
- R3: mode_code[3] is 1 in serializer mode (diri=1, not power-down) and 0 otherwise. mode_code[2] is always 0, so the codes are 0, 1..3 for deserializer and 9..11 for serializer.
- R4: overclock is 1 only in serializer mode with pll_sel=0, and is 0 when pll_sel=1. In deserializer mode pll_sel has no effect on any output.
- R5: diro is the combinational inverse of diri at all times, including reset and power-down.
- R6: par_out_en is 1 only while the deserializer is enabled, and ser_out_en only while the serializer is enabled.
- R7: A change of diri sampled at edge k makes both ser_en and des_en 0 after edge k. The enable for the new direction rises after edge k+1.
- R8: cksource_ref is cleared by reset and by power-down. It becomes 1 one clock after ckref_active=1 is sampled in serializer mode, and it then stays 1 across reference loss and direction changes until power-down or reset. Reference activity in deserializer mode or in power-down does not set it.
- R9: In serializer mode txclk_sel=1 (local bit clock) and wclk_sel=1 (received bit clock passed through). In deserializer mode txclk_sel=2 (strobe passed out) and wclk_sel=2 (recovered word clock). Both are 0 in power-down. All values are registered one clock after the inputs.
- R10: Synchronous reset puts every registered output in the power-down state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| s1 | input | 1 | Range-select bit 0 |
| s2 | input | 1 | Range-select bit 1 |
| pll_sel | input | 1 | 1 = standard multiplier, 0 = overclocked multiplier |
| diri | input | 1 | Direction: 1 = serializer, 0 = deserializer |
| ckref_active | input | 1 | Reference-clock activity detected |
| diro | output | 1 | Inverse of diri |
| mode_code | output | 4 | Registered operating mode code |
| ser_en | output | 1 | Serializer datapath enable |
| des_en | output | 1 | Deserializer datapath enable |
| par_out_en | output | 1 | Parallel port output driver enable |
| ser_out_en | output | 1 | Serial data output driver enable |
| pwrdn | output | 1 | Power-down and internal reset request |
| overclock | output | 1 | Overclocked multiplier active |
| rate_band | output | 2 | Selected reference-frequency band |
| cksource_ref | output | 1 | Serialization clock from local reference (else received bit clock) |
| txclk_sel | output | 2 | Transmitted clock route: 0 off, 1 local bit clock, 2 strobe |
| wclk_sel | output | 2 | Word-clock output route: 0 off, 1 received bit clock, 2 recovered word clock |

## Verification
The bench aims at the direction turnaround. A design without the quiet gap would show both datapaths, or the parallel driver, active in the cycle after a flip. A design that delayed too long would leave the new enable low after the second edge. The sticky clock-source latch is exercised by dropping the reference, by flipping direction, by showing reference activity in deserializer mode and in power-down, and by a mid-run reset. A latch that simply followed ckref_active, or that ignored the direction, would show the wrong clock source. The bench also checks that pll_sel is ignored in deserializer mode, and that the mode code still holds its old value just before the edge that registers a new range.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int MODE_W   = 4;
    localparam int SER_BIT  = 3;
    localparam int BAND_W   = 2;
    localparam int ROUTE_W  = 2;

    typedef enum logic [BAND_W-1:0] {
        BAND_OFF = 2'd0,
        BAND_HI  = 2'd1,
        BAND_LO  = 2'd2,
        BAND_MID = 2'd3
    } band_e;

    typedef enum logic [ROUTE_W-1:0] {
        TXCLK_OFF    = 2'd0,
        TXCLK_LOCAL  = 2'd1,
        TXCLK_STROBE = 2'd2
    } txclk_e;

    typedef enum logic [ROUTE_W-1:0] {
        WCLK_OFF       = 2'd0,
        WCLK_RXBIT     = 2'd1,
        WCLK_RECOVERED = 2'd2
    } wclk_e;

    typedef struct packed {
        logic  pd;
        logic  ser;
        band_e band;
        logic  oc;
    } opmode_t;

    localparam opmode_t OP_PWRDN = '{pd: 1'b1, ser: 1'b0, band: BAND_OFF, oc: 1'b0};

    function automatic logic [MODE_W-1:0] encode_mode(input opmode_t op);
        logic [MODE_W-1:0] code;
        code = '0;
        code[BAND_W-1:0] = op.band;
        code[SER_BIT]    = op.ser;
        return code;
    endfunction

    function automatic txclk_e route_tx(input opmode_t op);
        if (op.pd)       return TXCLK_OFF;
        else if (op.ser) return TXCLK_LOCAL;
        else             return TXCLK_STROBE;
    endfunction

    function automatic wclk_e route_w(input opmode_t op);
        if (op.pd)       return WCLK_OFF;
        else if (op.ser) return WCLK_RXBIT;
        else             return WCLK_RECOVERED;
    endfunction

endpackage

// File: rtl/sdc_mode_decode.sv
module sdc_mode_decode
    import sdc_pkg::*;
(
    input  logic    s1,
    input  logic    s2,
    input  logic    pll_sel,
    input  logic    diri,
    output opmode_t op,
    output logic    diro
);
    logic pd;

    assign pd   = ~(s1 | s2);
    assign diro = ~diri;

    always_comb begin
        op      = OP_PWRDN;
        op.pd   = pd;
        op.ser  = diri & ~pd;
        op.band = pd ? BAND_OFF : band_e'({s2, s1});
        op.oc   = diri & ~pd & ~pll_sel;
    end
endmodule

// File: rtl/sdc_turnaround.sv
module sdc_turnaround (
    input  logic clk,
    input  logic rst,
    input  logic diri,
    input  logic pd_req,
    output logic ser_en,
    output logic des_en
);
    logic dir_last;
    logic settled;

    assign settled = (diri == dir_last) & ~pd_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_last <= diri;
            ser_en   <= 1'b0;
            des_en   <= 1'b0;
        end else begin
            dir_last <= diri;
            ser_en   <= settled & diri;
            des_en   <= settled & ~diri;
        end
    end
endmodule

// File: rtl/sdc_clksrc_latch.sv
module sdc_clksrc_latch (
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    input  logic ser_req,
    input  logic ref_seen,
    output logic use_ref
);
    always_ff @(posedge clk) begin
        if (rst || pd_req)
            use_ref <= 1'b0;
        else if (ser_req && ref_seen)
            use_ref <= 1'b1;
    end
endmodule

// File: rtl/serdes_mode_ctl.sv
module serdes_mode_ctl
    import sdc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                s1,
    input  logic                s2,
    input  logic                pll_sel,
    input  logic                diri,
    input  logic                ckref_active,
    output logic                diro,
    output logic [MODE_W-1:0]   mode_code,
    output logic                ser_en,
    output logic                des_en,
    output logic                par_out_en,
    output logic                ser_out_en,
    output logic                pwrdn,
    output logic                overclock,
    output logic [BAND_W-1:0]   rate_band,
    output logic                cksource_ref,
    output logic [ROUTE_W-1:0]  txclk_sel,
    output logic [ROUTE_W-1:0]  wclk_sel
);
    opmode_t dec;
    opmode_t cur_q;
    txclk_e  tx_q;
    wclk_e   w_q;

    sdc_mode_decode u_dec (
        .s1      (s1),
        .s2      (s2),
        .pll_sel (pll_sel),
        .diri    (diri),
        .op      (dec),
        .diro    (diro)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= OP_PWRDN;
            tx_q  <= TXCLK_OFF;
            w_q   <= WCLK_OFF;
        end else begin
            cur_q <= dec;
            tx_q  <= route_tx(dec);
            w_q   <= route_w(dec);
        end
    end

    sdc_turnaround u_turn (
        .clk    (clk),
        .rst    (rst),
        .diri   (diri),
        .pd_req (dec.pd),
        .ser_en (ser_en),
        .des_en (des_en)
    );

    sdc_clksrc_latch u_csrc (
        .clk      (clk),
        .rst      (rst),
        .pd_req   (dec.pd),
        .ser_req  (dec.ser),
        .ref_seen (ckref_active),
        .use_ref  (cksource_ref)
    );

    assign mode_code  = encode_mode(cur_q);
    assign pwrdn      = cur_q.pd;
    assign overclock  = cur_q.oc;
    assign rate_band  = cur_q.band;
    assign par_out_en = des_en;
    assign ser_out_en = ser_en;
    assign txclk_sel  = tx_q;
    assign wclk_sel   = w_q;
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
    input logic       clk,
    input logic       rst,
    input logic       s1,
    input logic       s2,
    input logic       diri,
    input logic       diro,
    input logic [3:0] mode_code,
    input logic       ser_en,
    input logic       des_en,
    input logic       par_out_en,
    input logic       ser_out_en,
    input logic       pwrdn,
    input logic       cksource_ref,
    input logic [1:0] txclk_sel,
    input logic [1:0] wclk_sel
);
    AST_DIRO_INVERSE: assert property (@(posedge clk) diro != diri); // R5

    AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
        pwrdn |-> (mode_code == 4'd0) && !ser_en && !des_en && !par_out_en
                  && !ser_out_en && !cksource_ref); // R1

    AST_PD_ROUTE_OFF: assert property (@(posedge clk) disable iff (rst)
        pwrdn |-> (txclk_sel == 2'd0) && (wclk_sel == 2'd0)); // R9

    AST_BAND_REGISTERED: assert property (@(posedge clk) disable iff (rst)
        !rst |=> mode_code[1:0] == $past({s2, s1})); // R2

    AST_NO_BOTH_EN: assert property (@(posedge clk) disable iff (rst)
        !(ser_en && des_en)); // R7

    AST_SER_TO_DES_GAP: assert property (@(posedge clk) disable iff (rst)
        ser_en |=> !des_en); // R7

    AST_DES_TO_SER_GAP: assert property (@(posedge clk) disable iff (rst)
        des_en |=> !ser_en); // R7

    AST_PAR_ONLY_DES: assert property (@(posedge clk) disable iff (rst)
        par_out_en |-> !mode_code[3] && !pwrdn); // R6

    AST_SRC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cksource_ref && (s1 || s2)) |=> cksource_ref); // R8
endmodule

bind serdes_mode_ctl sdc_checker u_sdc_checker (
    .clk          (clk),
    .rst          (rst),
    .s1           (s1),
    .s2           (s2),
    .diri         (diri),
    .diro         (diro),
    .mode_code    (mode_code),
    .ser_en       (ser_en),
    .des_en       (des_en),
    .par_out_en   (par_out_en),
    .ser_out_en   (ser_out_en),
    .pwrdn        (pwrdn),
    .cksource_ref (cksource_ref),
    .txclk_sel    (txclk_sel),
    .wclk_sel     (wclk_sel)
);

// File: tb/tb_serdes_mode_ctl.sv
module tb_serdes_mode_ctl;

    logic       clk = 1'b0;
    logic       rst;
    logic       s1, s2, pll_sel, diri, ckref_active;
    logic       diro;
    logic [3:0] mode_code;
    logic       ser_en, des_en, par_out_en, ser_out_en, pwrdn, overclock;
    logic [1:0] rate_band;
    logic       cksource_ref;
    logic [1:0] txclk_sel, wclk_sel;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serdes_mode_ctl dut (
        .clk          (clk),
        .rst          (rst),
        .s1           (s1),
        .s2           (s2),
        .pll_sel      (pll_sel),
        .diri         (diri),
        .ckref_active (ckref_active),
        .diro         (diro),
        .mode_code    (mode_code),
        .ser_en       (ser_en),
        .des_en       (des_en),
        .par_out_en   (par_out_en),
        .ser_out_en   (ser_out_en),
        .pwrdn        (pwrdn),
        .overclock    (overclock),
        .rate_band    (rate_band),
        .cksource_ref (cksource_ref),
        .txclk_sel    (txclk_sel),
        .wclk_sel     (wclk_sel)
    );

    // inputs {s2,s1,pll_sel,diri,ckref} | mode | {pwrdn,overclock,ser_en,des_en,cksource_ref}
    localparam int NV = 13;
    localparam logic [13:0] VEC [0:NV-1] = '{
        {5'b00110, 4'h0, 5'b10000},
        {5'b01110, 4'h9, 5'b00100},
        {5'b01010, 4'h9, 5'b01100},
        {5'b10010, 4'hA, 5'b01100},
        {5'b11110, 4'hB, 5'b00100},
        {5'b11000, 4'h3, 5'b00010},
        {5'b10100, 4'h2, 5'b00010},
        {5'b01001, 4'h1, 5'b00010},
        {5'b01111, 4'h9, 5'b00101},
        {5'b01110, 4'h9, 5'b00101},
        {5'b11000, 4'h3, 5'b00011},
        {5'b00001, 4'h0, 5'b10000},
        {5'b10110, 4'hA, 5'b00100}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [4:0] v);
        {s2, s1, pll_sel, diri, ckref_active} = v;
    endtask

    initial begin
        #200000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(5'b01110);
        step();
        step();
        // R10 reset state
        check("R10 pwrdn", pwrdn, 1);
        check("R10 mode_code", mode_code, 0);
        check("R10 ser_en", ser_en, 0);
        check("R10 cksource_ref", cksource_ref, 0);
        check("R10 txclk_sel", txclk_sel, 0);
        check("R5 diro in reset", diro, 0);
        rst = 1'b0;
        step();
        check("R10 leave reset ser_en", ser_en, 1);

        for (int i = 0; i < NV; i++) begin
            logic [4:0] vin;
            logic [3:0] emode;
            logic [4:0] eflags;
            int         eroute;
            vin    = VEC[i][13:9];
            emode  = VEC[i][8:5];
            eflags = VEC[i][4:0];
            drive(vin);
            step();
            step();
            eroute = eflags[4] ? 0 : (vin[1] ? 1 : 2);
            check("R2/R3 mode_code", mode_code, emode);
            check("R2 rate_band", rate_band, emode[1:0]);
            check("R1 pwrdn", pwrdn, eflags[4]);
            check("R4 overclock", overclock, eflags[3]);
            check("R7 ser_en", ser_en, eflags[2]);
            check("R7 des_en", des_en, eflags[1]);
            check("R6 par_out_en", par_out_en, eflags[1]);
            check("R6 ser_out_en", ser_out_en, eflags[2]);
            check("R8 cksource_ref", cksource_ref, eflags[0]);
            check("R9 txclk_sel", txclk_sel, eroute);
            check("R9 wclk_sel", wclk_sel, eroute);
            check("R5 diro", diro, !vin[1]);
        end

        // R7 turnaround serializer -> deserializer (state: band 2, serializer)
        diri = 1'b0;
        #1 check("R5 diro after flip", diro, 1);
        step();
        check("R7 gap ser_en", ser_en, 0);
        check("R7 gap des_en", des_en, 0);
        check("R6 gap par_out_en", par_out_en, 0);
        check("R3 mode in gap", mode_code, 2);
        step();
        check("R7 des_en after gap", des_en, 1);
        check("R6 par_out_en after gap", par_out_en, 1);
        check("R9 txclk strobe", txclk_sel, 2);
        diri = 1'b1;
        step();
        check("R7 gap back des_en", des_en, 0);
        check("R7 gap back ser_en", ser_en, 0);
        check("R6 gap ser_out_en", ser_out_en, 0);
        step();
        check("R7 ser_en after gap", ser_en, 1);

        // R2 registration latency
        s1 = 1'b1;
        #1 check("R2 before edge", mode_code, 4'hA);
        step();
        check("R2 after edge", mode_code, 4'hB);

        // R8 latch set timing and stickiness
        ckref_active = 1'b1;
        #1 check("R8 before edge", cksource_ref, 0);
        step();
        check("R8 set", cksource_ref, 1);
        ckref_active = 1'b0;
        step(); step(); step();
        check("R8 sticky after ref loss", cksource_ref, 1);

        // R10 mid-run reset clears latch
        rst = 1'b1;
        step();
        check("R10 reset clears latch", cksource_ref, 0);
        check("R10 reset pwrdn", pwrdn, 1);
        rst = 1'b0;
        ckref_active = 1'b1;
        step();
        check("R8 set again", cksource_ref, 1);

        // R1 power-down clears latch and everything
        {s2, s1} = 2'b00;
        step();
        check("R1 pwrdn", pwrdn, 1);
        check("R1 latch cleared", cksource_ref, 0);
        check("R1 ser_out_en", ser_out_en, 0);
        check("R1 rate_band", rate_band, 0);
        check("R1 wclk_sel", wclk_sel, 0);

        // R4 pll_sel ignored in deserializer
        drive(5'b11000);
        step(); step();
        check("R4 des overclock pll0", overclock, 0);
        check("R4 des mode pll0", mode_code, 3);
        pll_sel = 1'b1;
        step();
        check("R4 des overclock pll1", overclock, 0);
        check("R4 des mode pll1", mode_code, 3);
        check("R4 des_en pll1", des_en, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule